// File: doc/BRIEF.md
# Injected and Regular Conversion Sequencer

This block decides which conversion a single filter unit runs next. The unit can read from any of `NCH` input channels. Two kinds of work compete for it. Injected work has high priority and comes from a software request or an external trigger. Regular work has low priority, comes only from a software request, and runs on one chosen channel, either once or over and over. The sequencer sends the filter datapath a one-cycle start pulse, the channel number and a busy flag. It receives an end-of-conversion pulse back, then gives a one-cycle done pulse for the class that finished, along with that channel number.

Requests wait in one pending slot per class. When the filter is idle, injected work always goes first. By default, an injected request that arrives during a regular conversion aborts it. The regular work is put back in the queue and runs again once the injected conversion ends. Regular work never interrupts injected work. A conversion on a disabled channel gets no data, so it does not finish. It stays active until the channel is enabled and ends, or until the global enable is cleared. Clearing the global enable stops everything.

Top module: `cnv_sequencer`

## Requirements
- R1: After reset, `busy`, `start`, `inj_done` and `reg_done` are all 0.
- R2: An injected request raises `start` for one cycle two clock edges after it is sampled. The request is either `inj_sw_req` high at an edge, or a rising edge of `inj_trig`. At that point `busy` is 1 and `act_ch` equals the sampled `inj_ch`.
- R3: Only `reg_sw_req` can start a regular conversion. A trigger edge, or a trigger held high, starts exactly one injected conversion and no regular conversion.
- R4: When both classes are pending while idle, the injected conversion starts first. The regular conversion starts after the injected one is done.
- R5: While an injected conversion is active, new requests do not start a conversion. `act_ch` stays unchanged until its end-of-conversion.
- R6: When `reg_cont` is 1 at a regular end-of-conversion, a new regular conversion starts on the cycle after `reg_done`, unless injected work is pending. When `reg_cont` is 0, the regular sequence stops.
- R7: With `PREEMPT`=1, an injected request that arrives during a regular conversion aborts it and starts the injected conversion. The regular conversion restarts after the injected one is done.
- R8: An end-of-conversion pulse is ignored while the active channel's bit in `ch_en` is 0. The conversion stays busy.
- R9: A hung conversion completes on the first end-of-conversion pulse after its channel is enabled.
- R10: When `filt_en` is low at an edge, `busy` and `start` are 0 after that edge, and both pending slots are cleared. Requests made while `filt_en` is low are dropped.
- R11: `inj_done` or `reg_done` goes high for one cycle, on the edge after the accepted end-of-conversion. At the same time `done_ch` shows the channel that was converted.
- R12: An injected request made during an injected conversion is held. It starts next, ahead of any pending regular work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_en | input | 1 | Global filter enable; low aborts and flushes |
| ch_en | input | NCH | Per-channel enable bits |
| inj_sw_req | input | 1 | Software injected request |
| inj_trig | input | 1 | External injected trigger |
| inj_ch | input | CHW | Channel for an injected request |
| reg_sw_req | input | 1 | Software regular request |
| reg_ch | input | CHW | Selected regular channel |
| reg_cont | input | 1 | Regular continuous mode |
| conv_eoc | input | 1 | End-of-conversion pulse from the datapath |
| start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | A conversion is active |
| act_ch | output | CHW | Channel of the active conversion |
| inj_done | output | 1 | Injected conversion finished |
| reg_done | output | 1 | Regular conversion finished |
| done_ch | output | CHW | Channel of the finished conversion |

## Verification
Some properties are checked on every cycle:
- An injected conversion keeps its state and channel until an accepted end-of-conversion arrives.
- Idle with injected work pending always leads to an injected start.
- A disabled channel keeps the conversion active.
- A low global enable leaves the block idle and both pending slots empty.
- A regular request can appear only from software, a re-arm or a requeue.
- Done pulses last one cycle.

Some behaviour only the directed scenarios can show:
- The exact start latency.
- Which channel follows which in priority order.
- A regular sequence resuming after preemption.
- Continuous restart timing.
- Release of a hung conversion by enabling its channel.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_INJ  = 2'd1,
      SQ_REG  = 2'd2
   } sq_state_t;

endpackage

// File: rtl/cnv_trig_detect.sv
module cnv_trig_detect #(
   parameter bit TRIG_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic hit_o
);

   generate
      if (TRIG_EDGE) begin : g_edge
         logic trig_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig_q <= 1'b0;
            else        trig_q <= trig_i;
         end
         assign hit_o = trig_i & ~trig_q;
      end else begin : g_level
         assign hit_o = trig_i;
      end
   endgenerate

endmodule

// File: rtl/cnv_req_queue.sv
module cnv_req_queue #(
   parameter int CHW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           filt_en,
   input  logic           inj_req_i,
   input  logic [CHW-1:0] inj_ch_i,
   input  logic           reg_req_i,
   input  logic           take_inj_i,
   input  logic           take_reg_i,
   input  logic           rearm_i,
   input  logic           requeue_i,
   output logic           inj_pend_o,
   output logic [CHW-1:0] inj_pch_o,
   output logic           reg_pend_o
);

   logic           inj_pend_q, reg_pend_q;
   logic [CHW-1:0] inj_pch_q;
   logic           inj_slot_free;

   assign inj_slot_free = ~inj_pend_q | take_inj_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_pend_q <= 1'b0;
         inj_pch_q  <= '0;
         reg_pend_q <= 1'b0;
      end else if (!filt_en) begin
         inj_pend_q <= 1'b0;
         reg_pend_q <= 1'b0;
      end else begin
         inj_pend_q <= (inj_pend_q & ~take_inj_i) | inj_req_i;
         if (inj_req_i && inj_slot_free) inj_pch_q <= inj_ch_i;
         reg_pend_q <= (reg_pend_q & ~take_reg_i) | reg_req_i | rearm_i | requeue_i;
      end
   end

   assign inj_pend_o = inj_pend_q;
   assign inj_pch_o  = inj_pch_q;
   assign reg_pend_o = reg_pend_q;

   // R10: a low enable empties both slots
   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en |=> (!inj_pend_q && !reg_pend_q));

   // R3: regular work appears only from software, re-arm or requeue
   p_reg_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_pend_q) |-> $past(reg_req_i || rearm_i || requeue_i));

   // R6: a continuous re-arm leaves regular work pending
   p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm_i && filt_en) |=> reg_pend_q);

endmodule

// File: rtl/cnv_sched.sv
module cnv_sched
   import cnv_seq_pkg::*;
#(
   parameter int NCH     = 8,
   parameter int CHW     = 3,
   parameter bit PREEMPT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           filt_en,
   input  logic [NCH-1:0] ch_en,
   input  logic           inj_pend_i,
   input  logic [CHW-1:0] inj_pch_i,
   input  logic           reg_pend_i,
   input  logic [CHW-1:0] reg_ch_i,
   input  logic           reg_cont_i,
   input  logic           conv_eoc_i,
   output logic           take_inj_o,
   output logic           take_reg_o,
   output logic           rearm_o,
   output logic           requeue_o,
   output logic           start_o,
   output logic           busy_o,
   output logic [CHW-1:0] act_ch_o,
   output logic           inj_done_o,
   output logic           reg_done_o,
   output logic [CHW-1:0] done_ch_o
);

   sq_state_t      st_q, st_n;
   logic [CHW-1:0] ch_q, ch_n, dch_q, dch_n;
   logic           start_q, start_n;
   logic           ijd_q, ijd_n, rgd_q, rgd_n;
   logic           eoc_ok, preempt;

   // a disabled channel supplies no data, so its end pulse is not accepted
   assign eoc_ok = conv_eoc_i && (st_q != SQ_IDLE) && ch_en[ch_q];

   generate
      if (PREEMPT) begin : g_abort
         assign preempt = (st_q == SQ_REG) && inj_pend_i;
      end else begin : g_wait
         assign preempt = 1'b0;
      end
   endgenerate

   always_comb begin
      st_n       = st_q;
      ch_n       = ch_q;
      dch_n      = dch_q;
      start_n    = 1'b0;
      ijd_n      = 1'b0;
      rgd_n      = 1'b0;
      take_inj_o = 1'b0;
      take_reg_o = 1'b0;
      rearm_o    = 1'b0;
      requeue_o  = 1'b0;
      if (!filt_en) begin
         st_n = SQ_IDLE;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (inj_pend_i) begin
                  st_n       = SQ_INJ;
                  ch_n       = inj_pch_i;
                  start_n    = 1'b1;
                  take_inj_o = 1'b1;
               end else if (reg_pend_i) begin
                  st_n       = SQ_REG;
                  ch_n       = reg_ch_i;
                  start_n    = 1'b1;
                  take_reg_o = 1'b1;
               end
            end
            SQ_INJ: begin
               if (eoc_ok) begin
                  st_n  = SQ_IDLE;
                  ijd_n = 1'b1;
                  dch_n = ch_q;
               end
            end
            SQ_REG: begin
               if (eoc_ok) begin
                  st_n    = SQ_IDLE;
                  rgd_n   = 1'b1;
                  dch_n   = ch_q;
                  rearm_o = reg_cont_i;
               end else if (preempt) begin
                  st_n       = SQ_INJ;
                  ch_n       = inj_pch_i;
                  start_n    = 1'b1;
                  take_inj_o = 1'b1;
                  requeue_o  = 1'b1;
               end
            end
            default: st_n = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         ch_q    <= '0;
         dch_q   <= '0;
         start_q <= 1'b0;
         ijd_q   <= 1'b0;
         rgd_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         ch_q    <= ch_n;
         dch_q   <= dch_n;
         start_q <= start_n;
         ijd_q   <= ijd_n;
         rgd_q   <= rgd_n;
      end
   end

   assign start_o    = start_q;
   assign busy_o     = (st_q != SQ_IDLE);
   assign act_ch_o   = ch_q;
   assign inj_done_o = ijd_q;
   assign reg_done_o = rgd_q;
   assign done_ch_o  = dch_q;

   // R5: injected work is never displaced before its accepted end
   p_inj_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_INJ && filt_en && !eoc_ok) |=> (st_q == SQ_INJ && $stable(ch_q)));

   // R4: idle with injected work pending always goes injected
   p_inj_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_IDLE && filt_en && inj_pend_i) |=> (st_q == SQ_INJ));

   // R8: a disabled channel keeps the conversion active
   p_hang_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != SQ_IDLE && filt_en && !ch_en[ch_q]) |=> (st_q != SQ_IDLE));

   // R10: a low enable leaves the sequencer idle with no start
   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en |=> (st_q == SQ_IDLE && !start_q));

   // R11: done pulses last a single cycle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ijd_q || rgd_q) |=> (!ijd_q && !rgd_q));

endmodule

// File: rtl/cnv_sequencer.sv
module cnv_sequencer #(
   parameter int NCH       = 8,
   parameter bit TRIG_EDGE = 1'b1,
   parameter bit PREEMPT   = 1'b1,
   localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           filt_en,
   input  logic [NCH-1:0] ch_en,
   input  logic           inj_sw_req,
   input  logic           inj_trig,
   input  logic [CHW-1:0] inj_ch,
   input  logic           reg_sw_req,
   input  logic [CHW-1:0] reg_ch,
   input  logic           reg_cont,
   input  logic           conv_eoc,
   output logic           start,
   output logic           busy,
   output logic [CHW-1:0] act_ch,
   output logic           inj_done,
   output logic           reg_done,
   output logic [CHW-1:0] done_ch
);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("cnv_sequencer: NCH must be at least 2");
      end
      if ((1 << CHW) != NCH) begin : g_bad_pow
         $error("cnv_sequencer: NCH must be a power of two");
      end
   endgenerate

   logic           trig_hit;
   logic           inj_pend, reg_pend;
   logic [CHW-1:0] inj_pch;
   logic           take_inj, take_reg, rearm, requeue;

   cnv_trig_detect #(.TRIG_EDGE(TRIG_EDGE)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (inj_trig),
      .hit_o  (trig_hit)
   );

   cnv_req_queue #(.CHW(CHW)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .filt_en    (filt_en),
      .inj_req_i  (inj_sw_req | trig_hit),
      .inj_ch_i   (inj_ch),
      .reg_req_i  (reg_sw_req),
      .take_inj_i (take_inj),
      .take_reg_i (take_reg),
      .rearm_i    (rearm),
      .requeue_i  (requeue),
      .inj_pend_o (inj_pend),
      .inj_pch_o  (inj_pch),
      .reg_pend_o (reg_pend)
   );

   cnv_sched #(.NCH(NCH), .CHW(CHW), .PREEMPT(PREEMPT)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .filt_en    (filt_en),
      .ch_en      (ch_en),
      .inj_pend_i (inj_pend),
      .inj_pch_i  (inj_pch),
      .reg_pend_i (reg_pend),
      .reg_ch_i   (reg_ch),
      .reg_cont_i (reg_cont),
      .conv_eoc_i (conv_eoc),
      .take_inj_o (take_inj),
      .take_reg_o (take_reg),
      .rearm_o    (rearm),
      .requeue_o  (requeue),
      .start_o    (start),
      .busy_o     (busy),
      .act_ch_o   (act_ch),
      .inj_done_o (inj_done),
      .reg_done_o (reg_done),
      .done_ch_o  (done_ch)
   );

endmodule

// File: tb/sim_cnv_sequencer.sv
module sim_cnv_sequencer;

   localparam int NCH = 8;
   localparam int CHW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           filt_en = 1'b0;
   logic [NCH-1:0] ch_en = '1;
   logic           inj_sw_req = 1'b0, inj_trig = 1'b0, reg_sw_req = 1'b0;
   logic           reg_cont = 1'b0, conv_eoc = 1'b0;
   logic [CHW-1:0] inj_ch = '0, reg_ch = '0;
   logic           start, busy, inj_done, reg_done;
   logic [CHW-1:0] act_ch, done_ch;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cnv_sequencer #(.NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .ch_en(ch_en),
      .inj_sw_req(inj_sw_req), .inj_trig(inj_trig), .inj_ch(inj_ch),
      .reg_sw_req(reg_sw_req), .reg_ch(reg_ch), .reg_cont(reg_cont),
      .conv_eoc(conv_eoc), .start(start), .busy(busy), .act_ch(act_ch),
      .inj_done(inj_done), .reg_done(reg_done), .done_ch(done_ch)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic eoc();
      conv_eoc = 1'b1;
      tick();
      conv_eoc = 1'b0;
   endtask

   task automatic inj_req(input int ch);
      inj_ch = CHW'(ch);
      inj_sw_req = 1'b1;
      tick();
      inj_sw_req = 1'b0;
   endtask

   task automatic reg_req(input int ch, input bit cont);
      reg_ch = CHW'(ch);
      reg_cont = cont;
      reg_sw_req = 1'b1;
      tick();
      reg_sw_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0);
      chk("R1 start", start, 0);
      chk("R1 done", inj_done | reg_done, 0);
   endtask

   task automatic t_inj_sw();
      inj_req(5);
      chk("R2 no start yet", start, 0);
      tick();
      chk("R2 start", start, 1);
      chk("R2 busy", busy, 1);
      chk("R2 act_ch", act_ch, 5);
      tick();
      chk("R2 start one cycle", start, 0);
      eoc();
      chk("R11 inj_done", inj_done, 1);
      chk("R11 done_ch", done_ch, 5);
      chk("R11 reg_done low", reg_done, 0);
      chk("R11 busy low", busy, 0);
      tick();
      chk("R11 pulse ends", inj_done, 0);
   endtask

   task automatic t_trigger();
      reg_ch = 3'd6;
      inj_ch = 3'd1;
      inj_trig = 1'b1;
      tick();
      tick();
      chk("R3 trig start", start, 1);
      chk("R3 trig is injected ch", act_ch, 1);
      tick();
      eoc();
      chk("R3 trig inj_done", inj_done, 1);
      for (int i = 0; i < 4; i++) tick();
      chk("R3 level held no second start", busy, 0);
      chk("R3 no regular done", reg_done, 0);
      inj_trig = 1'b0;
      tick();
   endtask

   task automatic t_both_pending();
      inj_ch = 3'd2;
      reg_ch = 3'd7;
      reg_cont = 1'b0;
      inj_sw_req = 1'b1;
      reg_sw_req = 1'b1;
      tick();
      inj_sw_req = 1'b0;
      reg_sw_req = 1'b0;
      tick();
      chk("R4 injected first", act_ch, 2);
      eoc();
      chk("R4 inj done", inj_done, 1);
      tick();
      chk("R4 regular next start", start, 1);
      chk("R4 regular ch", act_ch, 7);
      eoc();
      chk("R4 reg done", reg_done, 1);
      chk("R11 reg done_ch", done_ch, 7);
      tick();
   endtask

   task automatic t_no_reg_preempt();
      inj_req(0);
      tick();
      chk("R5 inj running", act_ch, 0);
      reg_req(3, 1'b0);
      inj_req(4);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R5 no new start", start, 0);
         chk("R5 ch held", act_ch, 0);
      end
      eoc();
      chk("R5 inj done", inj_done, 1);
      tick();
      chk("R12 pending inj next", act_ch, 4);
      chk("R12 start", start, 1);
      eoc();
      tick();
      chk("R12 then regular", act_ch, 3);
      eoc();
      chk("R12 regular done", reg_done, 1);
      tick();
   endtask

   task automatic t_continuous();
      reg_req(2, 1'b1);
      tick();
      chk("R6 first start", start, 1);
      eoc();
      chk("R6 reg done", reg_done, 1);
      chk("R6 idle at done", busy, 0);
      tick();
      chk("R6 restart next cycle", start, 1);
      chk("R6 restart ch", act_ch, 2);
      eoc();
      tick();
      chk("R6 restart again", start, 1);
      reg_cont = 1'b0;
      eoc();
      chk("R6 last done", reg_done, 1);
      tick();
      chk("R6 stop start", start, 0);
      chk("R6 stop busy", busy, 0);
   endtask

   task automatic t_preempt();
      reg_req(3, 1'b1);
      tick();
      chk("R7 regular running", act_ch, 3);
      inj_req(6);
      tick();
      chk("R7 injected start", start, 1);
      chk("R7 injected ch", act_ch, 6);
      eoc();
      chk("R7 inj done", inj_done, 1);
      chk("R7 no regular done", reg_done, 0);
      tick();
      chk("R7 regular resumes", start, 1);
      chk("R7 regular ch", act_ch, 3);
      reg_cont = 1'b0;
      eoc();
      chk("R7 regular done", reg_done, 1);
      tick();
   endtask

   task automatic t_hang();
      ch_en[2] = 1'b0;
      reg_req(2, 1'b0);
      tick();
      chk("R8 started", busy, 1);
      eoc();
      chk("R8 eoc ignored", reg_done, 0);
      chk("R8 still busy", busy, 1);
      tick();
      chk("R8 still busy later", busy, 1);
      ch_en[2] = 1'b1;
      tick();
      eoc();
      chk("R9 completes", reg_done, 1);
      chk("R9 done_ch", done_ch, 2);
      tick();
   endtask

   task automatic t_abort();
      ch_en[4] = 1'b0;
      reg_req(4, 1'b1);
      tick();
      chk("R10 hung busy", busy, 1);
      reg_sw_req = 1'b1;
      filt_en = 1'b0;
      tick();
      reg_sw_req = 1'b0;
      chk("R10 abort busy", busy, 0);
      chk("R10 abort start", start, 0);
      inj_req(1);
      filt_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R10 flushed", busy | start, 0);
      end
      ch_en[4] = 1'b1;
   endtask

   initial begin
      reg_cont = 1'b0;
      tick();
      t_reset();
      rst_n = 1'b1;
      filt_en = 1'b1;
      tick();
      t_reset();
      t_inj_sw();
      t_trigger();
      t_both_pending();
      t_no_reg_preempt();
      t_continuous();
      t_preempt();
      t_hang();
      t_abort();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule